// File: doc/BRIEF.md
# Asynchronous Static RAM Access Controller

This controller lets a clocked system read and write an external asynchronous static RAM of up to 128K bytes. The user side offers a request/ready handshake. Each request carries a read/write flag, an address and write data. A completed read returns its byte together with a one-cycle valid strobe.

On the memory side the controller drives an address bus and two chip selects of opposite polarity. It also drives active-low output and write enables, plus a tri-state data bus split into out, in and drive-enable signals.

The time each access holds its strobes is derived from the clock period and the memory's nanosecond minimums. Each phase is rounded up to whole cycles, so either speed grade can be met at any clock rate. With the defaults (8 ns clock, fast grade):

- A read holds its strobes for 5 cycles.
- A write holds write enable low for 4 cycles within a 5-cycle select window.
- After every read, 2 idle cycles let the memory release the bus.

While no access is in flight, the memory is deselected and rests in standby.

Top module: `sram_async_ctrl`

## Requirements
- R1: After synchronous reset: `mem_ce_n`=1, `mem_ce`=0, `mem_oe_n`=1, `mem_we_n`=1, `mem_dq_oe`=0, `ready`=1 and `rvalid`=0.
- R2: Whenever `ready` is high, the memory is deselected (`mem_ce_n`=1, `mem_ce`=0). In that state `mem_oe_n`=1, `mem_we_n`=1 and `mem_dq_oe`=0.
- R3: A read holds both chip selects active, `mem_we_n` high and `mem_oe_n` low for RD = ceil(max(tRC,tAA,tDOE)/T) cycles, which is 5 at defaults. It captures `mem_dq_i` at the end of that window and presents it on `rdata` with `rvalid` high for one cycle.
- R4: A write holds `mem_we_n` low for WE = ceil(max(tPWE,tSD,tSCE,tAW)/T) cycles, which is 4 at defaults. Throughout, both selects are active, `mem_oe_n` is high and `mem_dq_oe` drives the write data.
- R5: A write keeps the selects, address and data driven for WC = max(ceil(tWC/T), WE+1) cycles, which is 5 at defaults. `mem_we_n` rises at least one cycle before deselect. `ready` stays low for exactly WC cycles after the accepting edge.
- R6: `mem_dq_oe` is never high while `mem_oe_n` is low.
- R7: After a read's window, the controller stays deselected with `ready` low for HZ = max(1, ceil(tHZ/T)) further cycles, which is 2 at defaults. The total time `ready` is low for a read is RD+HZ, which is 7.
- R8: A request is accepted on a rising edge where `req` and `ready` are both high. `ready` is low in the following cycle. The address stays stable while the memory is selected.
- R9: A read returns the byte most recently written to that address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req | input | 1 | Access request |
| ready | output | 1 | Controller can accept a request |
| wr | input | 1 | 1 = write, 0 = read |
| addr | input | ADDR_W | Word address |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Read data |
| rvalid | output | 1 | One-cycle strobe for rdata |
| mem_addr | output | ADDR_W | Memory address bus |
| mem_ce_n | output | 1 | Active-low chip select |
| mem_ce | output | 1 | Active-high chip select |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_we_n | output | 1 | Active-low write enable |
| mem_dq_o | output | DATA_W | Data driven to memory |
| mem_dq_i | input | DATA_W | Data returned from memory |
| mem_dq_oe | output | 1 | Controller drives the data bus |

## Verification
The bench builds the controller with an 8-bit address (256 words) and fast-grade timing at an 8 ns clock. This makes every address reachable in a full write sweep, followed by a read-back sweep and an interleaved write-then-read sweep.

The bench's memory model returns the wrong byte until the read strobes have been held for the computed number of cycles. A controller that samples early therefore shows mismatched data. The per-access strobe and ready-low lengths are compared against cycle counts the bench derives from the nanosecond figures.

// File: rtl/sram_async_ctrl.sv
module sram_async_ctrl #(
  parameter int ADDR_W = 17,
  parameter int DATA_W = 8,
  parameter int CLK_NS = 8,
  parameter int T_RC   = 35,
  parameter int T_AA   = 35,
  parameter int T_DOE  = 10,
  parameter int T_WC   = 35,
  parameter int T_PWE  = 25,
  parameter int T_SCE  = 25,
  parameter int T_AW   = 25,
  parameter int T_SD   = 20,
  parameter int T_HZ   = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req,
  output logic              ready,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              rvalid,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_ce_n,
  output logic              mem_ce,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  output logic [DATA_W-1:0] mem_dq_o,
  input  logic [DATA_W-1:0] mem_dq_i,
  output logic              mem_dq_oe
);

  function automatic int cdiv(input int ns);
    return (ns + CLK_NS - 1) / CLK_NS;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  localparam int RD_CYC = imax(1, cdiv(imax(T_RC, imax(T_AA, T_DOE))));
  localparam int WE_CYC = imax(1, cdiv(imax(imax(T_PWE, T_SD), imax(T_SCE, T_AW))));
  localparam int WC_CYC = imax(cdiv(T_WC), WE_CYC + 1);
  localparam int HZ_CYC = imax(1, cdiv(T_HZ));
  localparam int MAX_CYC = imax(RD_CYC, imax(WC_CYC, HZ_CYC));
  localparam int CW = $clog2(MAX_CYC + 1);

  typedef enum logic [1:0] {S_IDLE, S_RD, S_WR, S_TURN} state_t;

  state_t        state;
  logic [CW-1:0] cnt;

  assign ready = (state == S_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= S_IDLE;
      cnt       <= '0;
      mem_ce_n  <= 1'b1;
      mem_ce    <= 1'b0;
      mem_oe_n  <= 1'b1;
      mem_we_n  <= 1'b1;
      mem_dq_oe <= 1'b0;
      mem_addr  <= '0;
      mem_dq_o  <= '0;
      rdata     <= '0;
      rvalid    <= 1'b0;
    end else begin
      rvalid <= 1'b0;
      case (state)
        S_IDLE: begin
          if (req) begin
            mem_addr <= addr;
            mem_ce_n <= 1'b0;
            mem_ce   <= 1'b1;
            cnt      <= '0;
            if (wr) begin
              mem_we_n  <= 1'b0;
              mem_dq_oe <= 1'b1;
              mem_dq_o  <= wdata;
              state     <= S_WR;
            end else begin
              mem_oe_n <= 1'b0;
              state    <= S_RD;
            end
          end
        end
        S_RD: begin
          cnt <= cnt + CW'(1);
          if (cnt == CW'(RD_CYC - 1)) begin
            rdata    <= mem_dq_i;
            rvalid   <= 1'b1;
            mem_ce_n <= 1'b1;
            mem_ce   <= 1'b0;
            mem_oe_n <= 1'b1;
            cnt      <= '0;
            state    <= S_TURN;
          end
        end
        S_WR: begin
          cnt <= cnt + CW'(1);
          if (cnt == CW'(WE_CYC - 1)) mem_we_n <= 1'b1;
          if (cnt == CW'(WC_CYC - 1)) begin
            mem_ce_n  <= 1'b1;
            mem_ce    <= 1'b0;
            mem_dq_oe <= 1'b0;
            state     <= S_IDLE;
          end
        end
        default: begin
          cnt <= cnt + CW'(1);
          if (cnt == CW'(HZ_CYC - 1)) state <= S_IDLE;
        end
      endcase
    end
  end

  a_r6_no_contention: assert property (@(posedge clk) disable iff (rst)
    mem_dq_oe |-> mem_oe_n);

  a_r4_write_selected: assert property (@(posedge clk) disable iff (rst)
    !mem_we_n |-> (!mem_ce_n && mem_ce && mem_oe_n && mem_dq_oe));

  a_r5_we_ends_first: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_ce_n) |-> $past(mem_we_n));

  a_r2_standby_idle: assert property (@(posedge clk) disable iff (rst)
    ready |-> (mem_ce_n && !mem_ce && mem_oe_n && mem_we_n));

  a_r3_rvalid_after_read: assert property (@(posedge clk) disable iff (rst)
    rvalid |-> $past(!mem_oe_n));

  a_r7_turn_after_read: assert property (@(posedge clk) disable iff (rst)
    rvalid |-> (!ready && mem_ce_n));

  a_r8_addr_stable: assert property (@(posedge clk) disable iff (rst)
    (!mem_ce_n && $past(!mem_ce_n)) |-> $stable(mem_addr));

endmodule

// File: tb/sram_async_ctrl_bench.sv
`timescale 1ns/1ps
module sram_async_ctrl_bench;
  localparam int AW = 8;
  localparam int DW = 8;
  localparam int T  = 8;

  function automatic int cdiv(input int ns);
    return (ns + T - 1) / T;
  endfunction

  localparam int RD_N = cdiv(35);
  localparam int WE_N = cdiv(25);
  localparam int WC_N = (cdiv(35) > WE_N + 1) ? cdiv(35) : WE_N + 1;
  localparam int HZ_N = (cdiv(10) > 1) ? cdiv(10) : 1;

  logic clk = 0;
  logic rst = 1;
  logic req = 0, wr = 0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic ready, rvalid, mem_ce_n, mem_ce, mem_oe_n, mem_we_n, mem_dq_oe;
  logic [DW-1:0] rdata, mem_dq_o, mem_dq_i;
  logic [AW-1:0] mem_addr;

  always #(T/2) clk = ~clk;

  sram_async_ctrl #(.ADDR_W(AW), .DATA_W(DW), .CLK_NS(T)) u_sram_async_ctrl (
    .clk(clk), .rst(rst), .req(req), .ready(ready), .wr(wr), .addr(addr),
    .wdata(wdata), .rdata(rdata), .rvalid(rvalid), .mem_addr(mem_addr),
    .mem_ce_n(mem_ce_n), .mem_ce(mem_ce), .mem_oe_n(mem_oe_n),
    .mem_we_n(mem_we_n), .mem_dq_o(mem_dq_o), .mem_dq_i(mem_dq_i),
    .mem_dq_oe(mem_dq_oe));

  int n_cmp = 0;
  int n_bad = 0;

  task automatic check(input bit ok, input string rq, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  logic [DW-1:0] mem [1<<AW];
  int rd_age = 0;
  int sel_run = 0, we_run = 0;
  bit saw_w = 0;
  logic [AW-1:0] last_a = '0;

  assign mem_dq_i = (rd_age >= RD_N) ? mem[mem_addr] : ~mem[mem_addr];

  always @(negedge clk) begin
    if (!rst) begin
      automatic bit sel = !mem_ce_n && mem_ce;
      automatic bit rd  = sel && !mem_oe_n && mem_we_n;
      if (mem_dq_oe && !mem_oe_n) check(0, "R6 contention", 1, 0);
      if (ready)
        check(!sel && mem_oe_n && mem_we_n && !mem_dq_oe, "R2 standby", sel, 0);
      if (sel && !mem_we_n) begin
        check(mem_dq_oe && mem_oe_n, "R4 bus during write", mem_dq_oe, 1);
        mem[mem_addr] = mem_dq_o;
      end
      if (rd && rd_age > 0 && mem_addr == last_a) rd_age++;
      else rd_age = rd ? 1 : 0;
      last_a = mem_addr;
      if (sel) begin
        sel_run++;
        if (!mem_we_n) begin
          we_run++;
          saw_w = 1;
        end
      end else if (sel_run > 0) begin
        if (saw_w) check(sel_run == WC_N, "R5 write select length", sel_run, WC_N);
        else       check(sel_run == RD_N, "R3 read strobe length", sel_run, RD_N);
        check(we_run == (saw_w ? WE_N : 0), "R4 write pulse length", we_run, saw_w ? WE_N : 0);
        sel_run = 0;
        we_run = 0;
        saw_w = 0;
      end
    end
  end

  task automatic access(input bit w, input logic [AW-1:0] a, input logic [DW-1:0] d,
                        output logic [DW-1:0] rd);
    int n;
    int got;
    @(negedge clk);
    while (!ready) @(negedge clk);
    req = 1; wr = w; addr = a; wdata = d;
    @(negedge clk);
    req = 0;
    check(!ready, "R8 ready drops after accept", ready, 0);
    n = 0;
    got = 0;
    rd = '0;
    while (!ready) begin
      n++;
      if (rvalid) begin
        got++;
        rd = rdata;
      end
      @(negedge clk);
    end
    if (rvalid) got++;
    if (w) check(n == WC_N, "R5 write busy cycles", n, WC_N);
    else   check(n == RD_N + HZ_N, "R7 read busy cycles", n, RD_N + HZ_N);
    check(got == (w ? 0 : 1), "R3 rvalid pulses", got, w ? 0 : 1);
  endtask

  function automatic logic [DW-1:0] pat1(input int a);
    return DW'((a * 37 + 11) & 8'hFF);
  endfunction

  initial begin
    for (int i = 0; i < 300000; i++) @(posedge clk);
    check(0, "watchdog", 0, 1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [DW-1:0] r;
    for (int i = 0; i < (1 << AW); i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    check(mem_ce_n && !mem_ce && mem_oe_n && mem_we_n && !mem_dq_oe,
          "R1 reset strobes", mem_ce_n, 1);
    check(ready && !rvalid, "R1 reset ready", ready, 1);
    for (int a = 0; a < (1 << AW); a++) access(1, AW'(a), pat1(a), r);
    for (int a = 0; a < (1 << AW); a++) begin
      access(0, AW'(a), '0, r);
      check(r == pat1(a), "R9 read back sweep", r, pat1(a));
    end
    for (int a = (1 << AW) - 1; a >= 0; a--) begin
      automatic logic [DW-1:0] e = DW'(a) ^ 8'hA5;
      access(1, AW'(a), e, r);
      access(0, AW'(a), '0, r);
      check(r == e, "R9 R3 write then read", r, e);
    end
    access(0, AW'(3), '0, r);
    check(r == (8'd3 ^ 8'hA5), "R9 neighbour kept", r, 8'd3 ^ 8'hA5);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule